// File: doc/BRIEF.md
# Floating-Point Status and Exception Controller

This block holds the status and control word of a floating-point unit. When the arithmetic datapath completes an operation, it reports five raw exception conditions: invalid, divide-by-zero, overflow, underflow and inexact. The controller copies them into a per-operation cause field and ORs them into a set of sticky flags. It also compares them with the software-set enable bits. When an enabled condition has occurred, it raises a one-cycle trap request that carries a fixed vector code.

The controller also decodes two controls from the stored word for the datapath: a round-toward-zero select and a denormal flush-to-zero select. Software loads the word through a write port. A fixed mask limits which bits that write can set.

An approximate-operation indicator accompanies the completion strobe. It marks results that are approximations by construction, and for those the controller reports inexact unless a stronger condition was already reported.

Top module: `fsr_ctrl`

## Requirements
- R1: After reset the stored word `csr_q` is 0, `trap_req` is 0, `rnd_zero` is 0 and `flush_dn` is 0.
- R2: A write stores `wr_data & 0x003FFFFF`. It is visible on `csr_q` in the cycle after `wr_en`, and bits 31:22 always read 0.
- R3: On an operation strobe (`op_done` without `wr_en`), the cause field, bits 16:12, is replaced by the adjusted flags of that operation. Bit 12 is inexact, 13 underflow, 14 overflow, 15 divide-by-zero and 16 invalid. The old cause is cleared even when no flag is raised. The result is visible in the next cycle.
- R4: On an operation strobe, the new cause bits are ORed into the sticky flags in bits 6:2, in the same order as the cause field. Operations never clear a sticky flag.
- R5: `trap_req` is high for exactly the cycle after an operation strobe when the new cause AND the stored enables (bits 11:7, same order) is nonzero. In that cycle `trap_code` is 0x120. Otherwise `trap_req` is 0 and `trap_code` is 0.
- R6: With `op_approx` set, inexact is forced to 1 only when invalid, divide-by-zero, overflow and underflow are all 0. Otherwise the flags pass unchanged. `op_flags` bit 0 is inexact, 1 underflow, 2 overflow, 3 divide-by-zero and 4 invalid.
- R7: `rnd_zero` is 1 exactly when `csr_q[1:0]` is 01. The encodings 00, 10 and 11 all select round-to-nearest-even (`rnd_zero` = 0).
- R8: `flush_dn` equals `csr_q[18]`.
- R9: When `wr_en` and `op_done` occur in the same cycle, the write takes effect and the operation is discarded. No cause or flag update and no trap result from it.
- R10: With neither `wr_en` nor `op_done` asserted, `csr_q` holds its value and `trap_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Status word write strobe |
| wr_data | input | 32 | Write value, masked on store |
| op_done | input | 1 | Operation-complete strobe |
| op_flags | input | 5 | Raw flags {V,Z,O,U,I}, bit 0 = inexact |
| op_approx | input | 1 | Completed operation is an approximation |
| csr_q | output | 32 | Stored status word |
| trap_req | output | 1 | One-cycle trap request |
| trap_code | output | 12 | Trap vector code, 0x120 while requesting |
| rnd_zero | output | 1 | Round-toward-zero select |
| flush_dn | output | 1 | Denormal flush-to-zero select |

## Verification
The bench aims at operations that raise no flag after one that did. A design that skips the cause clear would leave a stale cause and could trap on it. It runs approximate operations with and without a stronger flag, which catches a controller that always forces inexact or never does. Traps whose flag is set but not enabled, and traps whose flag and enable are both set, show whether the new cause or the sticky flags feed the enable compare. Simultaneous write and strobe show whether the write wins. Writes of all-ones and the four rounding encodings expose a wrong write mask or a rounding decode that checks only one bit.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int CSR_W     = 32;
  localparam int NFLAG     = 5;
  localparam int RM_LSB    = 0;
  localparam int RM_W      = 2;
  localparam int FLAG_LSB  = 2;
  localparam int EN_LSB    = FLAG_LSB + NFLAG;
  localparam int CAUSE_LSB = EN_LSB + NFLAG;
  localparam int DN_BIT    = 18;
  localparam int CODE_W    = 12;
  localparam logic [CSR_W-1:0]  WR_MASK  = 32'h003F_FFFF;
  localparam logic [CODE_W-1:0] TRAP_VEC = 12'h120;
  localparam logic [RM_W-1:0]   RM_RTZ   = 2'b01;
  // flag bit positions inside every 5-bit field
  localparam int FL_I = 0;
  localparam int FL_U = 1;
  localparam int FL_O = 2;
  localparam int FL_Z = 3;
  localparam int FL_V = 4;

  typedef logic [NFLAG-1:0] flag_t;
  typedef logic [CSR_W-1:0] csr_t;
endpackage

// File: rtl/fsr_flag_adjust.sv
module fsr_flag_adjust
  import fsr_pkg::*;
(
  input  flag_t raw,
  input  logic  approx,
  output flag_t adj
);
  logic others_clear;

  always_comb begin
    others_clear = ~(raw[FL_U] | raw[FL_O] | raw[FL_Z] | raw[FL_V]);
    adj = raw;
    if (approx && others_clear) adj[FL_I] = 1'b1;
  end
endmodule

// File: rtl/fsr_state.sv
module fsr_state
  import fsr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  csr_t wr_data,
  input  logic op_take,
  input  flag_t cause_new,
  output csr_t csr_q
);
  csr_t csr_d;

  always_comb begin
    csr_d = csr_q;
    if (wr_en) begin
      csr_d = wr_data & WR_MASK;
    end else if (op_take) begin
      for (int i = 0; i < NFLAG; i++) begin
        csr_d[CAUSE_LSB + i] = cause_new[i];
        csr_d[FLAG_LSB + i]  = csr_q[FLAG_LSB + i] | cause_new[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) csr_q <= '0;
    else     csr_q <= csr_d;
  end
endmodule

// File: rtl/fsr_trap_gen.sv
module fsr_trap_gen
  import fsr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic op_take,
  input  flag_t cause_new,
  input  flag_t enables,
  output logic trap_req,
  output logic [CODE_W-1:0] trap_code
);
  logic hit;

  always_comb hit = op_take && (|(cause_new & enables));

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_req  <= 1'b0;
      trap_code <= '0;
    end else begin
      trap_req  <= hit;
      trap_code <= hit ? TRAP_VEC : '0;
    end
  end
endmodule

// File: rtl/fsr_mode_decode.sv
module fsr_mode_decode
  import fsr_pkg::*;
(
  input  csr_t csr,
  output logic rnd_zero,
  output logic flush_dn
);
  always_comb begin
    rnd_zero = (csr[RM_LSB +: RM_W] == RM_RTZ);
    flush_dn = csr[DN_BIT];
  end
endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              op_done,
  input  logic [4:0]        op_flags,
  input  logic              op_approx,
  output logic [31:0]       csr_q,
  output logic              trap_req,
  output logic [11:0]       trap_code,
  output logic              rnd_zero,
  output logic              flush_dn
);
  flag_t cause_new;
  logic  op_take;

  // a write in the same cycle discards the operation
  always_comb op_take = op_done & ~wr_en;

  fsr_flag_adjust u_adj (
    .raw(op_flags), .approx(op_approx), .adj(cause_new)
  );

  fsr_state u_state (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .op_take(op_take), .cause_new(cause_new), .csr_q(csr_q)
  );

  fsr_trap_gen u_trap (
    .clk(clk), .rst(rst), .op_take(op_take), .cause_new(cause_new),
    .enables(csr_q[EN_LSB +: NFLAG]),
    .trap_req(trap_req), .trap_code(trap_code)
  );

  fsr_mode_decode u_mode (
    .csr(csr_q), .rnd_zero(rnd_zero), .flush_dn(flush_dn)
  );
endmodule

// File: rtl/fsr_ctrl_chk.sv
module fsr_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        op_done,
  input logic [31:0] csr_q,
  input logic        trap_req,
  input logic [11:0] trap_code
);
  AST_MASKED_BITS: assert property (@(posedge clk) disable iff (rst)
    csr_q[31:22] == 10'd0); // R2
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((csr_q[6:2] & $past(csr_q[6:2])) == $past(csr_q[6:2]))); // R4
  AST_TRAP_AFTER_OP: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> ($past(op_done) && !$past(wr_en))); // R5
  AST_TRAP_CODE: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> (trap_code == 12'h120)); // R5
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !trap_req); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !op_done) |=> ($stable(csr_q) && !trap_req)); // R10
endmodule

bind fsr_ctrl fsr_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .op_done(op_done),
  .csr_q(csr_q), .trap_req(trap_req), .trap_code(trap_code)
);

// File: tb/fsr_ctrl_tb.sv
`timescale 1ns/1ps
module fsr_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        op_done = 1'b0;
  logic [4:0]  op_flags = '0;
  logic        op_approx = 1'b0;
  logic [31:0] csr_q;
  logic        trap_req;
  logic [11:0] trap_code;
  logic        rnd_zero;
  logic        flush_dn;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] exp_csr = '0;
  logic        exp_trap = 1'b0;

  always #4 clk = ~clk;

  fsr_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .op_done(op_done), .op_flags(op_flags), .op_approx(op_approx),
    .csr_q(csr_q), .trap_req(trap_req), .trap_code(trap_code),
    .rnd_zero(rnd_zero), .flush_dn(flush_dn)
  );

  function automatic logic [4:0] adj_flags(logic [4:0] f, logic ap);
    logic [4:0] r = f;
    if (ap && f[4:1] == 4'b0) r[0] = 1'b1; // R6
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check({tag, " R2/R3/R4 csr"}, csr_q, exp_csr);
    check({tag, " R5 trap_req"}, {31'd0, trap_req}, {31'd0, exp_trap});
    check({tag, " R5 trap_code"}, {20'd0, trap_code}, exp_trap ? 32'h120 : 32'h0);
    check({tag, " R7 rnd_zero"}, {31'd0, rnd_zero}, {31'd0, exp_csr[1:0] == 2'b01});
    check({tag, " R8 flush_dn"}, {31'd0, flush_dn}, {31'd0, exp_csr[18]});
  endtask

  // drive at the falling edge, let one rising edge pass, check at the next falling edge
  task automatic step(string tag, logic we, logic [31:0] wd, logic od,
                      logic [4:0] fl, logic ap);
    logic [4:0] c;
    wr_en = we; wr_data = wd; op_done = od; op_flags = fl; op_approx = ap;
    c = adj_flags(fl, ap);
    exp_trap = 1'b0;
    if (we) begin
      exp_csr = wd & 32'h003F_FFFF; // R2, R9
    end else if (od) begin
      exp_trap = |(c & exp_csr[11:7]);
      exp_csr[16:12] = c;
      exp_csr[6:2] = exp_csr[6:2] | c;
    end
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1 reset");

    step("R2 all-ones write", 1, 32'hFFFF_FFFF, 0, 0, 0);
    step("R2 clear write", 1, 32'h0, 0, 0, 0);
    // R3: flags raised, then an operation with none clears the cause
    step("R3 raise", 0, 0, 1, 5'b10101, 0);
    step("R3 clear cause", 0, 0, 1, 5'b00000, 0);
    step("R10 idle", 0, 0, 0, 5'b11111, 1);
    // R6: approximate forcing
    step("R6 approx alone", 0, 0, 1, 5'b00000, 1);
    step("R6 approx with overflow", 0, 0, 1, 5'b00100, 1);
    step("R6 approx with inexact", 0, 0, 1, 5'b00001, 1);
    // R5: enable only divide-by-zero (bit 10)
    step("R5 enable Z", 1, 32'h0000_0400, 0, 0, 0);
    step("R5 no trap other flag", 0, 0, 1, 5'b10111, 0);
    step("R5 trap on Z", 0, 0, 1, 5'b01000, 0);
    step("R5 sticky Z no trap", 0, 0, 1, 5'b00000, 0);
    step("R5 back to back trap", 0, 0, 1, 5'b01000, 0);
    step("R5 back to back trap2", 0, 0, 1, 5'b11000, 0);
    // R9: write wins over a strobe
    step("R9 write wins", 1, 32'h0000_0F80, 1, 5'b11111, 0);
    // R6 trap via forced inexact: enable I (bit 7)
    step("R6 enable I", 1, 32'h0000_0080, 0, 0, 0);
    step("R6 forced I traps", 0, 0, 1, 5'b00000, 1);
    // R7/R8 decode
    for (int m = 0; m < 4; m++)
      step("R7 rounding", 1, {13'd0, 1'b1, 16'd0, m[1:0]}, 0, 0, 0);
    step("R8 flush off", 1, 32'h0000_0001, 0, 0, 0);

    for (int k = 0; k < 600; k++) begin
      logic we, od, ap;
      logic [31:0] wd;
      logic [4:0] fl;
      we = ($urandom % 10) == 0;
      od = ($urandom % 10) < 6;
      ap = ($urandom % 4) == 0;
      wd = $urandom;
      fl = ($urandom % 3 == 0) ? 5'b0 : 5'($urandom);
      step("R3/R4/R5/R6/R9/R10 random", we, wd, od, fl, ap);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule